// File: doc/BRIEF.md
# Pointer Code Insert and Verify Unit

This unit formats 64-bit virtual addresses for pointer authentication. A separate engine computes the 64-bit authentication code; this unit only places that code into a pointer, checks a signed pointer against a recomputed code, removes a code from a pointer, or reduces a code to a generic signature. The code field is a variable range of pointer bits. Its lower end is set by a 6-bit address-size input. Its upper end depends on whether the top byte of the pointer is reserved for tags.

A request is presented with `req_valid` high for one cycle, together with the mode, the configuration and the operands. The unit has two states. `S_IDLE` means no result is pending. `S_EMIT` means `result` holds the answer to the request of the previous cycle. The transition *accept* (either state to `S_EMIT`) fires on every cycle with `req_valid` high. The transition *drain* (`S_EMIT` to `S_IDLE`) fires on a cycle with `req_valid` low. `out_valid` is high exactly in `S_EMIT`. `result` holds its value in every cycle without a request.

Top module: `pac_ptr_fmt`

## Requirements
- R1: The code field is bits [bot, top) with bot = 64 − tsz and top = 56 when `tbi` = 1 or 64 when `tbi` = 0. When bot ≥ top (for example tsz = 0, or `tbi` = 1 with tsz ≤ 8), the field is empty and the pointer passes through strip mode unchanged.
- R2: Insert (`mode` = 2'b00). The extension bit e is `ptr[55]` when `tbi` = 1 and `ptr[63]` when `tbi` = 0. The result takes `ptr` outside the field, takes `code` inside the field except at bit 55, and ORs e into bit 55.
- R3: Insert with a malformed extension. If the `ptr` bits inside a non-empty field are neither all zeros nor all ones, one bit of the code is inverted before it is placed: bit 54 when `tbi` = 1, bit 62 when `tbi` = 0.
- R4: Strip (`mode` = 2'b10). If `ptr[55]` is 1, every field bit is set to one. Otherwise every field bit is cleared. All other bits pass through.
- R5: Verify (`mode` = 2'b01). When `code` XOR `ptr` is zero on every field bit other than bit 55, the result is the pointer restored as in R4.
- R6: Verify failure. When any such bit differs, the result is the restored pointer with a 2-bit error value {`key`, ~`key`} written to bits 54:53 when `tbi` = 1, or to bits 62:61 when `tbi` = 0.
- R7: Generic (`mode` = 2'b11). The result is `code[63:32]` in bits 63:32, with bits 31:0 zero.
- R8: `result` and `out_valid` are updated exactly one clock after a cycle with `req_valid` high. `out_valid` is low one clock after a cycle without a request, and `result` keeps its value.
- R9: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| mode | input | 2 | 00 insert, 01 verify, 10 strip, 11 generic |
| tbi | input | 1 | Top byte reserved for tags |
| tsz | input | 6 | Address-size field; field bottom is 64 − tsz |
| ptr | input | 64 | Pointer operand |
| code | input | 64 | Precomputed authentication code |
| key | input | 1 | Key number used in the verify error value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Formatted pointer or signature |

## Verification
The bench targets several corner cases:
- **Empty fields** (tsz = 0, or tagging with tsz ≤ 8). A design with wrong bound arithmetic would wrap around and clobber low pointer bits or the tag byte.
- **Malformed extensions in both tagging modes.** A design that flips the wrong bit, or never flips one, would leave a forged pointer indistinguishable from a correctly signed one.
- **Verify with both key values, and a mismatch confined to bit 55.** A design that swaps the error bits or their position would report the wrong key. A design that fails to mask bit 55 would reject valid pointers.
- **A request-free cycle.** This exposes a result register that does not hold its value, or a valid flag that stays high.

// File: rtl/pac_fmt_pkg.sv
package pac_fmt_pkg;
    parameter int PTR_W    = 64;
    parameter int TSZ_W    = 6;
    parameter int SEL_BIT  = 55;
    parameter int TAG_TOP  = 56;
    parameter int GEN_HALF = PTR_W / 2;
    parameter int IDX_W    = $clog2(PTR_W) + 1;

    typedef enum logic [1:0] {
        M_INSERT = 2'b00,
        M_VERIFY = 2'b01,
        M_STRIP  = 2'b10,
        M_GENERIC = 2'b11
    } mode_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } state_e;
endpackage

// File: rtl/pac_field_mask.sv
module pac_field_mask
    import pac_fmt_pkg::*;
(
    input  logic             tbi,
    input  logic [TSZ_W-1:0] tsz,
    output logic [PTR_W-1:0] fmask
);
    logic [IDX_W-1:0] bot;
    logic [IDX_W-1:0] top;

    always_comb begin
        bot = IDX_W'(PTR_W) - IDX_W'(tsz);
        top = tbi ? IDX_W'(TAG_TOP) : IDX_W'(PTR_W);
    end

    // An empty field (bot >= top) falls out of the per-bit test naturally.
    for (genvar i = 0; i < PTR_W; i++) begin : g_bit
        localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
        assign fmask[i] = (IDX >= bot) && (IDX < top);
    end
endmodule

// File: rtl/pac_insert_path.sv
module pac_insert_path
    import pac_fmt_pkg::*;
(
    input  logic             tbi,
    input  logic [PTR_W-1:0] fmask,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] code,
    output logic [PTR_W-1:0] signed_ptr
);
    localparam int FLIP_TAG   = TAG_TOP - 2;
    localparam int FLIP_NOTAG = PTR_W - 2;

    logic             ext;
    logic             any_one;
    logic             all_one;
    logic             malformed;
    logic [PTR_W-1:0] code_adj;
    logic [PTR_W-1:0] sel_mask;

    always_comb begin
        ext       = tbi ? ptr[SEL_BIT] : ptr[PTR_W-1];
        any_one   = |(ptr & fmask);
        all_one   = &(ptr | ~fmask);
        malformed = any_one && !all_one;
        code_adj  = code;
        if (malformed) begin
            if (tbi) code_adj[FLIP_TAG]   = ~code[FLIP_TAG];
            else     code_adj[FLIP_NOTAG] = ~code[FLIP_NOTAG];
        end
        sel_mask          = '0;
        sel_mask[SEL_BIT] = 1'b1;
        signed_ptr = (ptr & ~fmask) | (code_adj & fmask & ~sel_mask);
        signed_ptr[SEL_BIT] = signed_ptr[SEL_BIT] | ext;
    end
endmodule

// File: rtl/pac_verify_path.sv
module pac_verify_path
    import pac_fmt_pkg::*;
(
    input  logic             tbi,
    input  logic             key,
    input  logic [PTR_W-1:0] fmask,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] code,
    output logic [PTR_W-1:0] restored,
    output logic [PTR_W-1:0] checked
);
    localparam int ERR_TAG   = TAG_TOP - 3;
    localparam int ERR_NOTAG = PTR_W - 3;

    logic [PTR_W-1:0] diff;
    logic [1:0]       err;

    always_comb begin
        restored = ptr[SEL_BIT] ? (ptr | fmask) : (ptr & ~fmask);
        diff     = (code ^ ptr) & fmask;
        diff[SEL_BIT] = 1'b0;
        err      = {key, ~key};
        checked  = restored;
        if (|diff) begin
            if (tbi) checked[ERR_TAG+1:ERR_TAG]     = err;
            else     checked[ERR_NOTAG+1:ERR_NOTAG] = err;
        end
    end
endmodule

// File: rtl/pac_ptr_fmt.sv
module pac_ptr_fmt
    import pac_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       mode,
    input  logic             tbi,
    input  logic [TSZ_W-1:0] tsz,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] code,
    input  logic             key,
    output logic             out_valid,
    output logic [PTR_W-1:0] result
);
    state_e           state_q;
    state_e           state_d;
    mode_e            mode_op;
    logic [PTR_W-1:0] fmask;
    logic [PTR_W-1:0] ins_res;
    logic [PTR_W-1:0] rst_res;
    logic [PTR_W-1:0] chk_res;

    assign mode_op = mode_e'(mode);

    pac_field_mask u_mask (
        .tbi   (tbi),
        .tsz   (tsz),
        .fmask (fmask)
    );

    pac_insert_path u_ins (
        .tbi        (tbi),
        .fmask      (fmask),
        .ptr        (ptr),
        .code       (code),
        .signed_ptr (ins_res)
    );

    pac_verify_path u_ver (
        .tbi      (tbi),
        .key      (key),
        .fmask    (fmask),
        .ptr      (ptr),
        .code     (code),
        .restored (rst_res),
        .checked  (chk_res)
    );

    // Transitions: accept (any state -> S_EMIT), drain (S_EMIT -> S_IDLE).
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = req_valid ? S_EMIT : S_IDLE;
            S_EMIT:  state_d = req_valid ? S_EMIT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (req_valid) begin
            unique case (mode_op)
                M_INSERT:  result <= ins_res;
                M_VERIFY:  result <= chk_res;
                M_STRIP:   result <= rst_res;
                M_GENERIC: result <= {code[PTR_W-1:GEN_HALF], {GEN_HALF{1'b0}}};
                default:   result <= '0;
            endcase
        end
    end

    assign out_valid = (state_q == S_EMIT);

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(result)));

    // R2
    insert_sel_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b00 && (tbi ? ptr[SEL_BIT] : ptr[PTR_W-1]))
        |=> result[SEL_BIT]);

    // R7
    generic_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b11) |=> (result[GEN_HALF-1:0] == '0));

    // R4
    strip_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b10)
        |=> ((result & $past(fmask)) == (result[SEL_BIT] ? $past(fmask) : '0)));
endmodule

// File: tb/sim_pac_ptr_fmt.sv
module sim_pac_ptr_fmt;
    typedef struct packed {
        logic [1:0]  mode;
        logic        tbi;
        logic [5:0]  tsz;
        logic [63:0] ptr;
        logic [63:0] code;
        logic        key;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b00, 1'b0, 6'd16, 64'h0000_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{2'b00, 1'b1, 6'd16, 64'h5A80_7FFF_0000_1111, 64'h0123_4567_89AB_CDEF, 1'b0},
        '{2'b00, 1'b0, 6'd20, 64'hFFFF_F000_0000_0000, 64'hA5A5_A5A5_A5A5_A5A5, 1'b0},
        '{2'b00, 1'b0, 6'd24, 64'h0001_0000_0000_0000, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0},
        '{2'b00, 1'b1, 6'd39, 64'hC3FF_FFFF_FE00_0042, 64'h1357_9BDF_2468_ACE0, 1'b1},
        '{2'b00, 1'b0, 6'd0,  64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{2'b00, 1'b1, 6'd8,  64'h7700_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{2'b01, 1'b1, 6'd16, 64'h00AB_1234_5678_9ABC, 64'h0000_0000_0000_0000, 1'b1},
        '{2'b01, 1'b0, 6'd16, 64'hBE37_0000_1111_2222, 64'hBE37_0000_1111_2222, 1'b0},
        '{2'b01, 1'b0, 6'd20, 64'h4440_0000_0000_0008, 64'h4450_0000_0000_0008, 1'b0},
        '{2'b01, 1'b1, 6'd12, 64'h12F8_0000_0000_0FFF, 64'hFFF8_0000_0000_0000, 1'b1},
        '{2'b01, 1'b0, 6'd63, 64'h0000_0000_0000_0001, 64'h0080_0000_0000_0001, 1'b1},
        '{2'b10, 1'b1, 6'd16, 64'h3480_0000_DEAD_BEEF, 64'h0, 1'b0},
        '{2'b10, 1'b0, 6'd30, 64'h0012_3456_789A_BCDE, 64'h0, 1'b0},
        '{2'b10, 1'b1, 6'd4,  64'h9988_7766_5544_3322, 64'h0, 1'b0},
        '{2'b11, 1'b0, 6'd16, 64'h0, 64'h1122_3344_5566_7788, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        tbi = 1'b0;
    logic [5:0]  tsz = 6'd0;
    logic [63:0] ptr = '0;
    logic [63:0] code = '0;
    logic        key = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pac_ptr_fmt u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .mode      (mode),
        .tbi       (tbi),
        .tsz       (tsz),
        .ptr       (ptr),
        .code      (code),
        .key       (key),
        .out_valid (out_valid),
        .result    (result)
    );

    // Reference model built bit by bit from the requirements.
    function automatic logic [63:0] model(input vec_t v);
        int          bot = 64 - int'(v.tsz);
        int          top = v.tbi ? 56 : 64;
        logic        ext = v.tbi ? v.ptr[55] : v.ptr[63];
        logic [63:0] r = v.ptr;
        logic [63:0] c = v.code;
        logic        seen0 = 1'b0;
        logic        seen1 = 1'b0;
        logic        mism = 1'b0;
        case (v.mode)
            2'b00: begin
                for (int i = bot; i < top; i++) begin
                    if (v.ptr[i]) seen1 = 1'b1; else seen0 = 1'b1;
                end
                if (seen0 && seen1) c[top-2] = ~c[top-2];
                for (int i = bot; i < top; i++) r[i] = (i == 55) ? 1'b0 : c[i];
                r[55] = r[55] | ext;
            end
            2'b01: begin
                for (int i = bot; i < top; i++) begin
                    if (i != 55 && v.ptr[i] != v.code[i]) mism = 1'b1;
                    r[i] = v.ptr[55];
                end
                if (mism) begin
                    r[top-2] = v.key;
                    r[top-3] = ~v.key;
                end
            end
            2'b10: for (int i = bot; i < top; i++) r[i] = v.ptr[55];
            default: r = {v.code[63:32], 32'h0};
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1;
        mode = v.mode; tbi = v.tbi; tsz = v.tsz;
        ptr = v.ptr; code = v.code; key = v.key;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic directed(input string req, input vec_t v, input logic [63:0] exp);
        apply(v);
        check(req, {63'h0, out_valid}, 64'h1);
        check(req, result, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 out_valid", {63'h0, out_valid}, 64'h0);
        check("R9 result", result, 64'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k]);
            check("R8 out_valid", {63'h0, out_valid}, 64'h1);
            case (VECS[k].mode)
                2'b00:   check("R2/R3 insert", result, model(VECS[k]));
                2'b01:   check("R5/R6 verify", result, model(VECS[k]));
                2'b10:   check("R4/R1 strip", result, model(VECS[k]));
                default: check("R7 generic", result, model(VECS[k]));
            endcase
        end

        directed("R2 insert no tag",
            '{2'b00, 1'b0, 6'd16, 64'h0000_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
            64'hFF7F_1234_5678_9ABC);
        directed("R3 malformed tagged",
            '{2'b00, 1'b1, 6'd16, 64'h5A80_7FFF_0000_1111, 64'h0, 1'b0},
            64'h5AC0_7FFF_0000_1111);
        directed("R3 malformed untagged",
            '{2'b00, 1'b0, 6'd24, 64'h0001_0000_0000_0000, 64'h0, 1'b0},
            64'h4000_0000_0000_0000);
        directed("R6 verify fail key1",
            '{2'b01, 1'b1, 6'd16, 64'h00AB_1234_5678_9ABC, 64'h0, 1'b1},
            64'h00DF_1234_5678_9ABC);
        directed("R6 verify fail key0 untagged",
            '{2'b01, 1'b0, 6'd16, 64'h0000_0000_0000_0010, 64'h0001_0000_0000_0010, 1'b0},
            64'h2000_0000_0000_0010);
        directed("R5 verify pass bit55 ignored",
            '{2'b01, 1'b0, 6'd16, 64'h0080_0000_0000_0004, 64'h0000_0000_0000_0004, 1'b1},
            64'hFFFF_0000_0000_0004);
        directed("R1 empty field tagged strip",
            '{2'b10, 1'b1, 6'd8, 64'h9988_7766_5544_3322, 64'h0, 1'b0},
            64'h9988_7766_5544_3322);
        directed("R1 empty field tsz0 strip",
            '{2'b10, 1'b0, 6'd0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0},
            64'h1234_5678_9ABC_DEF0);
        directed("R7 generic",
            '{2'b11, 1'b1, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1122_3344_5566_7788, 1'b0},
            64'h1122_3344_0000_0000);

        // R8 drain: no request, valid drops, result holds
        @(negedge clk);
        check("R8 drain out_valid", {63'h0, out_valid}, 64'h0);
        check("R8 hold result", result, 64'h1122_3344_0000_0000);

        // R9 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset result", result, 64'h0);
        check("R9 reset out_valid", {63'h0, out_valid}, 64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule